// File: doc/BRIEF.md
# Multi-View FIFO Communication Cell

A single storage cell that carries data between hardware threads as a small FIFO of eight 64-bit entries. Every access names a view that sets its meaning. The raw view peeks at the oldest entry or patches the newest one. The tag view reads and writes the cell's status word. The two queue views push on writes and pop on reads. One queue view blocks and the other is non-blocking.

A blocking access that cannot complete returns a stall flag. The cell then records the requester in a mask of waiters. The next queue access that completes sends every recorded waiter a one-cycle pulse on the wake vector and clears the mask. A woken requester retries the access it made before. Halting threads and bus decoding sit outside this block.

Top module: `mv_fifo_cell`

## Requirements
- R1: After reset the cell is empty and in FIFO mode. The tag word reads 0x30020001: empty flag set, full flag clear, user bit clear, count 0, and a depth code of log2(DEPTH)=3.
- R2: A tag-view read (view_i=1) returns the status word with this layout: empty at bit 0, full at bit 1, user bit at bit 16, FIFO-mode flag at bit 17, fill count starting at bit 18, depth code starting at bit 28.
- R3: A tag-view write loads the user, empty and full bits from bits 16, 0 and 1 of wdata_i. Writing the empty bit as 1 also clears the fill count.
- R4: A raw-view read (view_i=0) returns the oldest entry and does not pop it.
- R5: A raw-view write replaces the newest entry when the count is above zero. On an empty cell it changes nothing.
- R6: A queue read (view_i=2 blocking, 3 non-blocking) that proceeds clears the full bit. It pops and returns the oldest entry when the count is above zero, and returns 0 otherwise. The empty bit is set once the count is 0. Entries leave in write order, and the read pointer wraps modulo DEPTH.
- R7: A queue write that proceeds clears the empty bit. It stores at (read pointer + count) mod DEPTH when the cell is not full. The full bit is set when the count reaches DEPTH. A non-blocking write to a full cell is dropped.
- R8: A blocking read that finds the empty bit set asserts stall_o and returns 0. It leaves the count unchanged, still clears the full bit, and records rid_i as a waiter.
- R9: A blocking write that finds the full bit set asserts stall_o, leaves the count unchanged and records rid_i as a waiter.
- R10: Any queue access that proceeds pulses wake_o with every recorded waiter for exactly one cycle and clears the record.
- R11: rdata_o, stall_o and wake_o are registered and appear one cycle after the request. rdata_o and stall_o are 0 in cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| view_i | input | 2 | 0 raw, 1 tag, 2 blocking queue, 3 non-blocking queue |
| wdata_i | input | 64 | Write data |
| rid_i | input | 2 | Requester number |
| rdata_o | output | 64 | Read data, one cycle after the request |
| stall_o | output | 1 | Blocking access could not complete |
| wake_o | output | 4 | One-cycle wake pulse, one bit per requester |

## Verification
Each access is a one-cycle request. Its read data, stall flag and wake bits come from the clock edge that samples it. The bench drives on a falling edge and reads all three outputs at the next falling edge, which is half a cycle after they settle. Internal state is checked through tag-view reads that follow each scenario. The one-cycle width of the wake pulse is checked with an idle cycle after the pulse, in which wake_o must read zero.

// File: rtl/mvc_pkg.sv
package mvc_pkg;
  typedef enum logic [1:0] {
    VIEW_RAW  = 2'd0,
    VIEW_TAG  = 2'd1,
    VIEW_WAIT = 2'd2,
    VIEW_POLL = 2'd3
  } view_e;

  localparam int TAG_E     = 0;
  localparam int TAG_F     = 1;
  localparam int TAG_T     = 16;
  localparam int TAG_MODE  = 17;
  localparam int TAG_CNT   = 18;
  localparam int TAG_DCODE = 28;
  localparam int DCODE_W   = 4;
endpackage

// File: rtl/mvc_store.sv
module mvc_store #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == PW'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mvc_tag.sv
module mvc_tag #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic          ctl_t_i,
  input  logic          ctl_e_i,
  input  logic          ctl_f_i,
  input  logic          ef_rd_i,
  input  logic          ef_wr_i,
  input  logic          go_i,
  output logic          e_o,
  output logic          f_o,
  output logic          t_o,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] rptr_o,
  output logic          pop_o,
  output logic          push_o
);
  logic          e_q, f_q, t_q, e_d, f_d, t_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] rp_q, rp_d;

  assign pop_o  = ef_rd_i && go_i && (cnt_q != '0);
  assign push_o = ef_wr_i && go_i && (cnt_q < CW'(DEPTH));

  always_comb begin
    e_d = e_q; f_d = f_q; t_d = t_q; cnt_d = cnt_q; rp_d = rp_q;
    if (ctl_wr_i) begin
      t_d = ctl_t_i; e_d = ctl_e_i; f_d = ctl_f_i;
      if (ctl_e_i) cnt_d = '0;
    end else if (ef_rd_i) begin
      f_d = 1'b0;
      if (go_i) begin
        if (pop_o) begin
          cnt_d = cnt_q - 1'b1;
          rp_d  = rp_q + 1'b1;
        end
        if (cnt_d == '0) e_d = 1'b1;
      end
    end else if (ef_wr_i) begin
      e_d = 1'b0;
      if (go_i) begin
        if (push_o) cnt_d = cnt_q + 1'b1;
        if (cnt_d == CW'(DEPTH)) f_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q <= 1'b1; f_q <= 1'b0; t_q <= 1'b0; cnt_q <= '0; rp_q <= '0;
    end else begin
      e_q <= e_d; f_q <= f_d; t_q <= t_d; cnt_q <= cnt_d; rp_q <= rp_d;
    end
  end

  assign e_o = e_q; assign f_o = f_q; assign t_o = t_q;
  assign cnt_o = cnt_q; assign rptr_o = rp_q;

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R7
  full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && cnt_q == CW'(DEPTH - 1)) |=> f_q);
  // R6
  empty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && cnt_q == CW'(1)) |=> e_q);
  // R8
  hold_on_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ef_rd_i || ef_wr_i) && !go_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mvc_waiters.sv
module mvc_waiters #(
  parameter int NREQ = 4,
  localparam int RW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            block_i,
  input  logic [RW-1:0]   rid_i,
  input  logic            release_i,
  output logic [NREQ-1:0] wake_o
);
  logic [NREQ-1:0] mask_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      wake_q <= '0;
    end else begin
      wake_q <= release_i ? mask_q : '0;
      if (release_i)    mask_q <= '0;
      else if (block_i) mask_q <= mask_q | (NREQ'(1) << rid_i);
    end
  end

  assign wake_o = wake_q;

  // R10
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wake_q) |=> (wake_q == '0));
  // R10
  wake_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wake_q) |-> $past(|mask_q));
endmodule

// File: rtl/mv_fifo_cell.sv
module mv_fifo_cell #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int NREQ  = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [1:0]      view_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [RW-1:0]   rid_i,
  output logic [DW-1:0]   rdata_o,
  output logic            stall_o,
  output logic [NREQ-1:0] wake_o
);
  import mvc_pkg::*;

  view_e         vw;
  logic          ef_acc, blk, go, ef_rd, ef_wr, ctl_wr, byp_wr;
  logic          e, f, t, pop, push;
  logic [CW-1:0] cnt;
  logic [PW-1:0] rp, waddr;
  logic [DW-1:0] mem_rd, tag_word, rd_d, rdata_q;
  logic          stall_q;

  assign vw     = view_e'(view_i);
  assign ef_acc = req_i && (vw == VIEW_WAIT || vw == VIEW_POLL);
  assign blk    = ef_acc && (vw == VIEW_WAIT) && (we_i ? f : e);
  assign go     = ef_acc && !blk;
  assign ef_rd  = ef_acc && !we_i;
  assign ef_wr  = ef_acc && we_i;
  assign ctl_wr = req_i && we_i && (vw == VIEW_TAG);
  assign byp_wr = req_i && we_i && (vw == VIEW_RAW) && (cnt != '0);

  // push lands after the newest entry, raw write overwrites the newest
  assign waddr = push ? (rp + cnt[PW-1:0]) : (rp + cnt[PW-1:0] - 1'b1);

  mvc_tag #(.DEPTH(DEPTH)) u_tag (
    .clk_i, .rst_ni,
    .ctl_wr_i (ctl_wr),
    .ctl_t_i  (wdata_i[TAG_T]),
    .ctl_e_i  (wdata_i[TAG_E]),
    .ctl_f_i  (wdata_i[TAG_F]),
    .ef_rd_i  (ef_rd),
    .ef_wr_i  (ef_wr),
    .go_i     (go),
    .e_o      (e),
    .f_o      (f),
    .t_o      (t),
    .cnt_o    (cnt),
    .rptr_o   (rp),
    .pop_o    (pop),
    .push_o   (push)
  );

  mvc_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i,
    .we_i    (push || byp_wr),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (rp),
    .rdata_o (mem_rd)
  );

  mvc_waiters #(.NREQ(NREQ)) u_wait (
    .clk_i, .rst_ni,
    .block_i   (blk),
    .rid_i     (rid_i),
    .release_i (go),
    .wake_o    (wake_o)
  );

  always_comb begin
    tag_word = '0;
    tag_word[TAG_E]    = e;
    tag_word[TAG_F]    = f;
    tag_word[TAG_T]    = t;
    tag_word[TAG_MODE] = 1'b1;
    tag_word[TAG_CNT +: CW]        = cnt;
    tag_word[TAG_DCODE +: DCODE_W] = DCODE_W'(PW);
  end

  always_comb begin
    rd_d = '0;
    if (req_i && !we_i) begin
      unique case (vw)
        VIEW_RAW: rd_d = mem_rd;
        VIEW_TAG: rd_d = tag_word;
        default:  rd_d = pop ? mem_rd : '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      stall_q <= 1'b0;
    end else begin
      rdata_q <= rd_d;
      stall_q <= blk;
    end
  end

  assign rdata_o = rdata_q;
  assign stall_o = stall_q;

  // R8
  stall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> $past(req_i && view_i == 2'd2));
  // R11
  quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> (rdata_o == '0 && !stall_o));
endmodule

// File: tb/sim_mv_fifo_cell.sv
`timescale 1ns/1ps
module sim_mv_fifo_cell;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  view = '0;
  logic [63:0] wdata = '0;
  logic [1:0]  rid = '0;
  logic [63:0] rdata;
  logic        stall;
  logic [3:0]  wake;

  logic [63:0] g_rd;
  logic        g_st;
  logic [3:0]  g_wk;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mv_fifo_cell u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .view_i(view),
    .wdata_i(wdata), .rid_i(rid), .rdata_o(rdata), .stall_o(stall), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; req = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic acc(input logic w, input logic [1:0] v, input logic [63:0] d, input logic [1:0] id);
    @(negedge clk);
    req = 1'b1; we = w; view = v; wdata = d; rid = id;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
    g_rd = rdata; g_st = stall; g_wk = wake;
  endtask

  task automatic tag_is(input string tag, input logic [63:0] exp);
    acc(1'b0, 2'd1, '0, 2'd0);
    chk(tag, g_rd, exp);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R11 idle rdata", rdata, '0);
    chk("R11 idle stall", 64'(stall), '0);
    tag_is("R1 R2 reset tag", 64'h3002_0001);
    chk("R1 reset wake", 64'(g_wk), '0);
  endtask

  task automatic t_order();
    acc(1'b1, 2'd3, 64'hA1, 2'd0);
    chk("R11 write rdata zero", g_rd, '0);
    acc(1'b1, 2'd3, 64'hB2, 2'd0);
    acc(1'b1, 2'd3, 64'hC3, 2'd0);
    tag_is("R2 count 3", 64'h300E_0000);
    acc(1'b0, 2'd0, '0, 2'd0);
    chk("R4 raw read oldest", g_rd, 64'hA1);
    acc(1'b0, 2'd0, '0, 2'd0);
    chk("R4 raw read no pop", g_rd, 64'hA1);
    acc(1'b0, 2'd3, '0, 2'd0); chk("R6 pop 1", g_rd, 64'hA1);
    acc(1'b0, 2'd3, '0, 2'd0); chk("R6 pop 2", g_rd, 64'hB2);
    acc(1'b0, 2'd3, '0, 2'd0); chk("R6 pop 3", g_rd, 64'hC3);
    tag_is("R6 empty after drain", 64'h3002_0001);
    acc(1'b0, 2'd3, '0, 2'd0);
    chk("R6 empty poll returns 0", g_rd, '0);
    chk("R6 empty poll no stall", 64'(g_st), '0);
  endtask

  // continues from t_order: read pointer is 3, so pushes wrap
  task automatic t_full();
    for (int i = 0; i < 8; i++) acc(1'b1, 2'd2, 64'h100 + 64'(i), 2'd0);
    tag_is("R7 full tag", 64'h3022_0002);
    acc(1'b1, 2'd2, 64'hBEEF, 2'd3);
    chk("R9 blocking write stalls", 64'(g_st), 64'd1);
    tag_is("R9 count held", 64'h3022_0002);
    acc(1'b1, 2'd3, 64'hDEAD, 2'd0);
    chk("R7 poll write full no stall", 64'(g_st), '0);
    chk("R10 wake writer waiter", 64'(g_wk), 64'h8);
    @(negedge clk);
    chk("R10 wake one cycle", 64'(wake), '0);
    tag_is("R7 dropped write", 64'h3022_0002);
    acc(1'b0, 2'd3, '0, 2'd0);
    chk("R6 R7 wrap pop first", g_rd, 64'h100);
    tag_is("R6 full cleared", 64'h301E_0000);
    for (int i = 1; i < 8; i++) begin
      acc(1'b0, 2'd2, '0, 2'd0);
      chk("R6 wrap order", g_rd, 64'h100 + 64'(i));
    end
    tag_is("R6 empty again", 64'h3002_0001);
  endtask

  task automatic t_raw_write();
    do_reset();
    acc(1'b1, 2'd0, 64'hBAD, 2'd0);
    tag_is("R5 raw write on empty ignored", 64'h3002_0001);
    acc(1'b1, 2'd3, 64'h11, 2'd0);
    acc(1'b0, 2'd0, '0, 2'd0);
    chk("R4 raw read", g_rd, 64'h11);
    acc(1'b1, 2'd3, 64'h22, 2'd0);
    acc(1'b1, 2'd0, 64'h33, 2'd0);
    tag_is("R5 count kept", 64'h300A_0000);
    acc(1'b0, 2'd3, '0, 2'd0); chk("R5 oldest kept", g_rd, 64'h11);
    acc(1'b0, 2'd3, '0, 2'd0); chk("R5 newest replaced", g_rd, 64'h33);
  endtask

  task automatic t_wait_read();
    do_reset();
    acc(1'b0, 2'd2, '0, 2'd1);
    chk("R8 blocking read stalls", 64'(g_st), 64'd1);
    chk("R8 stalled rdata", g_rd, '0);
    acc(1'b0, 2'd2, '0, 2'd2);
    chk("R8 second waiter stalls", 64'(g_st), 64'd1);
    tag_is("R8 state held", 64'h3002_0001);
    acc(1'b1, 2'd3, 64'h55, 2'd0);
    chk("R10 wake both readers", 64'(g_wk), 64'h6);
    @(negedge clk);
    chk("R10 pulse ends", 64'(wake), '0);
    acc(1'b0, 2'd2, '0, 2'd1);
    chk("R8 retry gets data", g_rd, 64'h55);
    chk("R10 mask cleared", 64'(g_wk), '0);
  endtask

  task automatic t_tag_write();
    do_reset();
    acc(1'b1, 2'd1, 64'h1_0000, 2'd0);
    tag_is("R3 load T, clear E", 64'h3003_0000);
    acc(1'b1, 2'd3, 64'h7, 2'd0);
    acc(1'b1, 2'd3, 64'h8, 2'd0);
    acc(1'b1, 2'd1, 64'h3, 2'd0);
    tag_is("R3 E write clears count", 64'h3002_0003);
    acc(1'b0, 2'd2, '0, 2'd2);
    chk("R8 read stalls on E", 64'(g_st), 64'd1);
    tag_is("R8 stalled read clears F", 64'h3002_0001);
    acc(1'b1, 2'd1, 64'h2, 2'd0);
    tag_is("R3 F only", 64'h3002_0002);
    acc(1'b1, 2'd2, 64'h9, 2'd1);
    chk("R9 write stalls on F", 64'(g_st), 64'd1);
    acc(1'b0, 2'd3, '0, 2'd0);
    chk("R6 poll read on count 0", g_rd, '0);
    chk("R10 wake reader and writer", 64'(g_wk), 64'h6);
    tag_is("R6 F cleared, E set", 64'h3002_0001);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_raw_write();
    t_wait_read();
    t_tag_write();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule